// File: doc/BRIEF.md
# D-PHY Test Port Write Sequencer

This block turns a single write request, made of an 8-bit test code and an 8-bit data byte, into the full pin sequence on the slow serial configuration port of a D-PHY. That port has four signals: a clear line, a strobe line, an enable line and an 8-bit data bus. A write begins with a clear pulse. The code is presented with enable high and is captured on a falling strobe edge. The byte is then presented with enable low and is captured on the next rising strobe edge. The strobe finally returns low.

Each pin-level step holds for `PHASE_CYC` system clock cycles, so the slow port meets its setup and hold times. A request is taken through a valid/ready handshake. `busy` stays high for the whole sequence, and `done` pulses once when it ends. A typical use is loading the high-speed frequency-range selection, whose test code is 0x44.

When no sequence runs, two direct-control registers own the pins, so software can drive the port by hand. When a sequence finishes, it hands the pins back with the values it ended on, so the pins show no glitch.

Top module: `dphy_tst_wr_master`

## Requirements
- R1: After reset, the pins are clear=1, strobe=0, enable=0 and data bus=0. `busy` and `done` are 0 and `req_ready` is 1.
- R2: A request is accepted in a cycle where `req_valid` and `req_ready` are both 1. `busy` is 1 and `req_ready` is 0 from the next cycle until the sequence ends.
- R3: A sequence opens with two clear steps. The first is clear=1, strobe=0, enable=0, data bus=0. The second is the same but with clear=0.
- R4: The address steps follow in this order: strobe=1 with enable=0 and bus=0; then strobe=1, enable=1, bus=code; then strobe=0, enable=1, bus=code. The code is captured on that falling edge.
- R5: The data steps follow in this order: strobe=0, enable=0, bus=data; then strobe=1, enable=0, bus=data; then strobe=0, enable=0, bus=data. Clear stays 0 through all address and data steps.
- R6: Each of the eight steps lasts exactly `PHASE_CYC` cycles (`PHASE_CYC` must be at least 2). `busy` is therefore high for 8*`PHASE_CYC` cycles.
- R7: `done` is 1 for exactly one cycle, the first cycle after `busy` falls. From that cycle on, the pins rest at clear=0, strobe=0, enable=0 and bus=data until the next write.
- R8: A request that arrives while `busy` is 1 is ignored. It changes neither the running sequence nor its length.
- R9: While idle, a register write takes effect on the pins one cycle later. With `reg_addr`=0, `reg_wdata` bit 0 sets clear and bit 1 sets strobe. With `reg_addr`=1, bit 16 sets enable and bits 7:0 set the data bus.
- R10: A register write while `busy` is 1 is ignored. A register write in the same cycle that a request is accepted is also ignored.
- R11: Within a sequence, no cycle changes strobe and enable together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block can accept a request (idle) |
| req_code | input | 8 | Test code to write |
| req_data | input | 8 | Test data byte to write |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse at sequence end |
| reg_we | input | 1 | Direct-control register write strobe |
| reg_addr | input | 1 | 0 selects the clear/strobe register, 1 the enable/bus register |
| reg_wdata | input | 32 | Direct-control write data |
| phy_testclr | output | 1 | Test port clear |
| phy_testclk | output | 1 | Test port strobe |
| phy_testen | output | 1 | Test port enable (high = code, low = data) |
| phy_testdin | output | 8 | Test port data bus |

## Verification
An accepted request shows its first clear step on the pins one cycle after the accepting edge. Step k then appears k*`PHASE_CYC` cycles later. `busy` drops and `done` rises exactly 8*`PHASE_CYC` cycles after acceptance, and a register write shows on the pins one cycle after it is presented. The reference model advances once per clock on the inputs just driven, so its expectation always describes the cycle after the next rising edge. Outputs are compared at every falling edge against that expectation, which places each check in the cycle where the result is due. Requests and register writes are also thrown in mid-sequence and on the accepting cycle, and are checked to leave the pin sequence and its length unchanged.

// File: rtl/dphy_tst_pkg.sv
package dphy_tst_pkg;

    localparam int TST_DW    = 8;
    localparam int REG_DW    = 32;
    localparam int CLR_BIT   = 0;
    localparam int CK_BIT    = 1;
    localparam int EN_BIT    = 16;
    localparam int NUM_STEPS = 8;

    localparam logic [TST_DW-1:0] HSFREQ_CODE = 8'h44;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLR_ON,
        ST_CLR_OFF,
        ST_CK_UP,
        ST_ADDR_EN,
        ST_ADDR_FALL,
        ST_DATA_SET,
        ST_DATA_RISE,
        ST_CK_DOWN
    } step_e;

    typedef struct packed {
        logic              clr;
        logic              ck;
        logic              en;
        logic [TST_DW-1:0] din;
    } pins_t;

    function automatic pins_t step_pins(step_e s, logic [TST_DW-1:0] code,
                                        logic [TST_DW-1:0] data);
        pins_t p;
        p = '{clr: 1'b0, ck: 1'b0, en: 1'b0, din: '0};
        case (s)
            ST_CLR_ON:    p.clr = 1'b1;
            ST_CLR_OFF:   p.clr = 1'b0;
            ST_CK_UP:     p.ck  = 1'b1;
            ST_ADDR_EN:   begin p.ck = 1'b1; p.en = 1'b1; p.din = code; end
            ST_ADDR_FALL: begin p.en = 1'b1; p.din = code; end
            ST_DATA_SET:  p.din = data;
            ST_DATA_RISE: begin p.ck = 1'b1; p.din = data; end
            ST_CK_DOWN:   p.din = data;
            default:      p.clr = 1'b0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/dphy_tst_timer.sv
module dphy_tst_timer #(
    parameter int PHASE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PHASE_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    assign tick = run && (tmr_q.cnt == LAST);

    always_comb begin
        tmr_d = tmr_q;
        if (restart) begin
            tmr_d.cnt = '0;
        end else if (run) begin
            tmr_d.cnt = tick ? '0 : tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end
endmodule

// File: rtl/dphy_tst_seq.sv
module dphy_tst_seq
    import dphy_tst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [TST_DW-1:0] code_in,
    input  logic [TST_DW-1:0] data_in,
    input  logic              tick,
    output logic              busy,
    output logic              finish,
    output logic              done,
    output pins_t             seq_pins,
    output logic [TST_DW-1:0] last_data
);
    typedef struct packed {
        step_e             step;
        logic [TST_DW-1:0] code;
        logic [TST_DW-1:0] data;
        logic              done;
    } seq_t;

    seq_t seq_d, seq_q;

    assign busy      = (seq_q.step != ST_IDLE);
    assign finish    = (seq_q.step == ST_CK_DOWN) && tick;
    assign done      = seq_q.done;
    assign seq_pins  = step_pins(seq_q.step, seq_q.code, seq_q.data);
    assign last_data = seq_q.data;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = finish;
        if (seq_q.step == ST_IDLE) begin
            if (start) begin
                seq_d.step = ST_CLR_ON;
                seq_d.code = code_in;
                seq_d.data = data_in;
            end
        end else if (tick) begin
            if (seq_q.step == ST_CK_DOWN) seq_d.step = ST_IDLE;
            else                          seq_d.step = step_e'(seq_q.step + 4'd1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{step: ST_IDLE, code: '0, data: '0, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end
endmodule

// File: rtl/dphy_tst_regs.sv
module dphy_tst_regs
    import dphy_tst_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [REG_DW-1:0] wr_data,
    input  logic              load_end,
    input  logic [TST_DW-1:0] end_din,
    output pins_t             reg_pins
);
    typedef struct packed {
        pins_t pins;
    } regs_t;

    regs_t regs_d, regs_q;

    assign reg_pins = regs_q.pins;

    always_comb begin
        regs_d = regs_q;
        if (load_end) begin
            regs_d.pins = '{clr: 1'b0, ck: 1'b0, en: 1'b0, din: end_din};
        end else if (wr_en) begin
            if (!wr_addr) begin
                regs_d.pins.clr = wr_data[CLR_BIT];
                regs_d.pins.ck  = wr_data[CK_BIT];
            end else begin
                regs_d.pins.en  = wr_data[EN_BIT];
                regs_d.pins.din = wr_data[TST_DW-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '{pins: '{clr: 1'b1, ck: 1'b0, en: 1'b0, din: '0}};
        else        regs_q <= regs_d;
    end
endmodule

// File: rtl/dphy_tst_wr_master.sv
module dphy_tst_wr_master
    import dphy_tst_pkg::*;
#(
    parameter int PHASE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [TST_DW-1:0] req_code,
    input  logic [TST_DW-1:0] req_data,
    output logic              busy,
    output logic              done,
    input  logic              reg_we,
    input  logic              reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic              phy_testclr,
    output logic              phy_testclk,
    output logic              phy_testen,
    output logic [TST_DW-1:0] phy_testdin
);
    logic              accept;
    logic              tick;
    logic              seq_busy;
    logic              seq_finish;
    logic              reg_wr_ok;
    logic [TST_DW-1:0] seq_last_data;
    pins_t             seq_pins;
    pins_t             reg_pins;
    pins_t             out_pins;

    assign req_ready = !seq_busy;
    assign busy      = seq_busy;
    assign accept    = req_valid && !seq_busy;
    assign reg_wr_ok = reg_we && !seq_busy && !accept;

    dphy_tst_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (accept),
        .run     (seq_busy),
        .tick    (tick)
    );

    dphy_tst_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .code_in   (req_code),
        .data_in   (req_data),
        .tick      (tick),
        .busy      (seq_busy),
        .finish    (seq_finish),
        .done      (done),
        .seq_pins  (seq_pins),
        .last_data (seq_last_data)
    );

    dphy_tst_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_ok),
        .wr_addr  (reg_addr),
        .wr_data  (reg_wdata),
        .load_end (seq_finish),
        .end_din  (seq_last_data),
        .reg_pins (reg_pins)
    );

    assign out_pins    = seq_busy ? seq_pins : reg_pins;
    assign phy_testclr = out_pins.clr;
    assign phy_testclk = out_pins.ck;
    assign phy_testen  = out_pins.en;
    assign phy_testdin = out_pins.din;
endmodule

// File: rtl/dphy_tst_chk.sv
module dphy_tst_chk #(
    parameter int PHASE_CYC = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       busy,
    input logic       done,
    input logic       phy_testclr,
    input logic       phy_testclk,
    input logic       phy_testen,
    input logic [7:0] phy_testdin
);
    localparam int SEQ_LEN = 8 * PHASE_CYC;
    localparam int RUN_W   = $clog2(SEQ_LEN + 1);

    logic [RUN_W-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)    run_cnt <= '0;
        else if (busy) run_cnt <= run_cnt + 1'b1;
        else           run_cnt <= '0;
    end

    a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> busy);

    a_r3_clear_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> phy_testclr && !phy_testclk && !phy_testen && (phy_testdin == 8'h00));

    a_r4_code_held_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $fell(phy_testclk) && phy_testen |-> $stable(phy_testdin) && $past(phy_testen));

    a_r5_data_held_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $rose(phy_testclk) && !phy_testen |-> $stable(phy_testdin) && $stable(phy_testen));

    a_r6_seq_length: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> run_cnt == RUN_W'(SEQ_LEN));

    a_r8_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run_cnt < RUN_W'(SEQ_LEN));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_rest: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !phy_testclr && !phy_testclk && !phy_testen);

    a_r11_one_edge: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> !(!$stable(phy_testclk) && !$stable(phy_testen)));
endmodule

bind dphy_tst_wr_master dphy_tst_chk #(.PHASE_CYC(PHASE_CYC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .busy        (busy),
    .done        (done),
    .phy_testclr (phy_testclr),
    .phy_testclk (phy_testclk),
    .phy_testen  (phy_testen),
    .phy_testdin (phy_testdin)
);

// File: tb/sim_dphy_tst_wr_master.sv
module sim_dphy_tst_wr_master;
    localparam int P   = 4;
    localparam int LEN = 8 * P;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_code = '0;
    logic [7:0]  req_data = '0;
    logic        reg_we = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        req_ready, busy, done;
    logic        phy_testclr, phy_testclk, phy_testen;
    logic [7:0]  phy_testdin;

    always #4 clk = ~clk;

    dphy_tst_wr_master #(.PHASE_CYC(P)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_code(req_code), .req_data(req_data),
        .busy(busy), .done(done),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .phy_testclr(phy_testclr), .phy_testclk(phy_testclk),
        .phy_testen(phy_testen), .phy_testdin(phy_testdin)
    );

    int applied = 0;
    int errors  = 0;

    // reference model state
    int         left = 0;
    logic [7:0] m_code = '0, m_data = '0;
    logic       s_clr = 1'b1, s_ck = 1'b0, s_en = 1'b0;
    logic [7:0] s_din = '0;
    logic       m_done = 1'b0;
    string      idle_tag = "R1";

    // observation history
    int   run_obs = 0;
    logic prev_busy = 1'b0, prev_ck = 1'b0, prev_en = 1'b0;

    function automatic logic [10:0] exp_step(int s, logic [7:0] c, logic [7:0] d);
        case (s)
            0: return {1'b1, 1'b0, 1'b0, 8'h00};   // R3 clear on
            1: return {1'b0, 1'b0, 1'b0, 8'h00};   // R3 clear off
            2: return {1'b0, 1'b1, 1'b0, 8'h00};   // R4 strobe up
            3: return {1'b0, 1'b1, 1'b1, c};       // R4 code, enable high
            4: return {1'b0, 1'b0, 1'b1, c};       // R4 falling capture
            5: return {1'b0, 1'b0, 1'b0, d};       // R5 data setup
            6: return {1'b0, 1'b1, 1'b0, d};       // R5 rising capture
            default: return {1'b0, 1'b0, 1'b0, d}; // R5 strobe low
        endcase
    endfunction

    function automatic string step_tag(int s);
        if (s < 2) return "R3";
        if (s < 5) return "R4";
        return "R5";
    endfunction

    task automatic check(string tag, string what, int act, int expv);
        applied++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", tag, what, act, expv, $time);
        end
    endtask

    task automatic compare();
        logic [10:0] e, a;
        string tag;
        a = {phy_testclr, phy_testclk, phy_testen, phy_testdin};
        if (left > 0) begin
            e   = exp_step((LEN - left) / P, m_code, m_data);
            tag = step_tag((LEN - left) / P);
        end else begin
            e   = {s_clr, s_ck, s_en, s_din};
            tag = m_done ? "R7" : idle_tag;
        end
        check(tag, "pins{clr,clk,en,din}", int'(a), int'(e));
        check("R2", "busy", int'(busy), int'(left > 0));
        check("R2", "req_ready", int'(req_ready), int'(left == 0));
        check("R7", "done", int'(done), int'(m_done));
        if (busy && prev_busy && (phy_testclk != prev_ck) && (phy_testen != prev_en))
            check("R11", "strobe and enable changed together", 1, 0);
        if (busy) run_obs++;
        if (done) begin
            check("R6", "busy cycle count", run_obs, LEN);
            run_obs = 0;
        end
        prev_busy = busy; prev_ck = phy_testclk; prev_en = phy_testen;
    endtask

    task automatic model_step(logic v, logic [7:0] c, logic [7:0] d,
                              logic we, logic a, logic [31:0] wd);
        logic nd;
        nd = 1'b0;
        if (left > 0) begin
            left--;
            if (left == 0) begin
                s_clr = 1'b0; s_ck = 1'b0; s_en = 1'b0; s_din = m_data;
                nd = 1'b1;
            end
        end else if (v) begin
            left = LEN; m_code = c; m_data = d;
        end else if (we) begin
            if (!a) begin s_clr = wd[0]; s_ck = wd[1]; end
            else    begin s_en = wd[16]; s_din = wd[7:0]; end
        end
        m_done = nd;
    endtask

    task automatic cyc(logic v, logic [7:0] c, logic [7:0] d,
                       logic we, logic a, logic [31:0] wd);
        @(negedge clk);
        compare();
        req_valid = v; req_code = c; req_data = d;
        reg_we = we; reg_addr = a; reg_wdata = wd;
        model_step(v, c, d, we, a, wd);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 32'h0);
    endtask

    task automatic run_write(logic [7:0] c, logic [7:0] d);
        cyc(1'b1, c, d, 1'b0, 1'b0, 32'h0);
        for (int i = 0; i < LEN + 2; i++) cyc(1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state held while idle
        idle(3);
        // R3 R4 R5 R6 R7: frequency-range code write
        idle_tag = "R7";
        run_write(8'h44, 8'h2A);
        run_write(8'hFF, 8'h00);
        run_write(8'h81, 8'h7E);
        // R8 R10: requests and register writes while busy are ignored
        cyc(1'b1, 8'h5A, 8'hC3, 1'b0, 1'b0, 32'h0);
        for (int i = 0; i < LEN - 1; i++) begin
            if (i % 3 == 0) cyc(1'b1, 8'h11, 8'h22, 1'b0, 1'b0, 32'h0);
            else if (i % 3 == 1) cyc(1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 32'h3);
            else cyc(1'b0, 8'h00, 8'h00, 1'b1, 1'b1, 32'h0001_00EE);
        end
        idle(3);
        // R9: direct register writes while idle
        idle_tag = "R9";
        cyc(1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 32'h0000_0003);
        cyc(1'b0, 8'h00, 8'h00, 1'b1, 1'b1, 32'h0001_0055);
        idle(2);
        cyc(1'b0, 8'h00, 8'h00, 1'b1, 1'b1, 32'hFFFE_FFAA);
        cyc(1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 32'hFFFF_FFFE);
        cyc(1'b0, 8'h00, 8'h00, 1'b1, 1'b0, 32'h0000_0000);
        idle(2);
        // R10: register write in the accepting cycle is ignored
        idle_tag = "R10";
        cyc(1'b1, 8'h3C, 8'h96, 1'b1, 1'b1, 32'h0001_0011);
        idle(LEN + 2);
        // R2 R8: back-to-back requests with valid held high
        idle_tag = "R2";
        for (int i = 0; i < 2 * LEN + 2; i++) cyc(1'b1, 8'hA5, 8'h0F, 1'b0, 1'b0, 32'h0);
        idle(LEN + 4);
        $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
        $finish;
    end

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL R6 watchdog actual=timeout expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
        $finish;
    end
endmodule